// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This block gathers eight edge-triggered interrupt requests and presents the most urgent one to a processor on a single interrupt line. A request is latched when its input rises. It can be held off by a per-level mask bit. It can also be blocked while a level of equal or higher priority is in service. The processor answers with a one-cycle acknowledge pulse. The controller then moves the winning level from pending into service and returns an 8-bit vector one cycle later.

Software programs the block through a byte-wide command port with one address bit. Writing an initialization word starts the setup sequence, which loads the vector base and selects automatic end-of-interrupt. Operation words then do four jobs:
- write the mask;
- retire in-service levels, either the highest one or a named one;
- rotate or set the priority order;
- switch special mask mode on or off and select which register the status port shows.

The priority order is circular. The level just above the current lowest-priority level is the most urgent. In special mask mode, in-service levels stop blocking other requests, and a general end-of-interrupt leaves masked in-service levels alone.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `irq_in[n]` sets pending bit n. `stat_out` shows the pending register, or the in-service register once a status-select word (A0=0, bit3=1, bit1=1) has been written with bit0=1. The same word with bit0=0 selects the pending register again.
- R2: An A0=0 write with bit4=1 starts initialization. Bit1=1 means single mode, so no third word is expected. Bit0=1 means a fourth word follows. This write clears the mask, selects the pending register for status, leaves special mask mode, clears rotate-on-auto-EOI, and sets the lowest-priority level to 7. The next A0=1 write gives the vector base in bits 7:3. In the fourth word, bit1 selects automatic end-of-interrupt.
- R3: Priority runs from lowest-priority+1 upwards, modulo 8. `int_out` is high when the first unmasked pending level in that order is reached before any in-service level. An in-service bit blocks its own level and every level after it.
- R4: After initialization, an A0=1 write loads the mask. A set mask bit keeps that level from raising `int_out`.
- R5: An `inta` pulse while `int_out` is high clears the winner's pending bit and sets its in-service bit (when not in automatic mode). In the next cycle `vec_out` = {base, level} with `vec_vld` high.
- R6: Command word 2 (A0=0, bit4=0, bit3=0) has these fields: bit7 rotate, bit6 specific, bit5 end-of-interrupt, bits 2:0 level. The value 0x20 clears the in-service bit that comes first in priority order.
- R7: End-of-interrupt with the specific bit set (0x60|L) clears in-service bit L only.
- R8: End-of-interrupt with the rotate bit set makes the cleared level the lowest-priority level.
- R9: Command 0xC0|L (rotate and specific, no end-of-interrupt) makes L the lowest-priority level.
- R10: In command word 3, bit6 gates bit5 into special mask mode; when bit6 is 0 the mode is left unchanged. In this mode in-service bits block no request.
- R11: In special mask mode, a general end-of-interrupt skips in-service bits whose mask bit is set.
- R12: In automatic mode an acknowledge sets no in-service bit. Command 0x80 turns rotate-on-auto-EOI on and 0x00 turns it off. While it is on, the acknowledged level becomes the lowest-priority level.
- R13: If a new rising edge arrives on the acknowledged level in the same cycle as the acknowledge, that level stays pending.
- R14: An `inta` while `int_out` is low returns vector {base, 7} and changes no pending or in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Edge-triggered request inputs |
| cmd_wr | input | 1 | Command write strobe |
| cmd_a0 | input | 1 | Command address bit |
| cmd_data | input | 8 | Command byte |
| inta | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_vld | output | 1 | Vector valid, one cycle after `inta` |
| stat_out | output | 8 | Pending or in-service register, per select |
| mask_out | output | 8 | Current mask register |

## Verification
Two functions can land on the same pending bit in the same cycle: clearing it for an acknowledge, and setting it for a new request edge. The bench provokes this by raising the level's input in the very cycle the acknowledge pulse is driven. The check passes only if the line stays asserted afterwards and a second acknowledge returns the same vector. Vectors are judged by a scoreboard that queues the expected vector before each acknowledge and compares it with the next valid vector.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_in,
  input  logic            cmd_wr,
  input  logic            cmd_a0,
  input  logic [7:0]      cmd_data,
  input  logic            inta,
  output logic            int_out,
  output logic [7:0]      vec_out,
  output logic            vec_vld,
  output logic [NLVL-1:0] stat_out,
  output logic [NLVL-1:0] mask_out
);
  localparam int LW = $clog2(NLVL);
  localparam int BW = 8 - LW;

  typedef enum logic [1:0] {ST_RDY, ST_W2, ST_W3, ST_W4} init_t;

  init_t           st, st_n;
  logic [NLVL-1:0] irq_q, irr, isr, imr, irr_n, isr_n, imr_n;
  logic [LW-1:0]   lowp, lowp_n, win, eoi_lvl;
  logic [BW-1:0]   base, base_n;
  logic            smm, smm_n, rd_isr, rd_isr_n, aeoi, aeoi_n, rot_aeoi, rot_n;
  logic            need3, need3_n, need4, need4_n;
  logic            win_ok, eoi_ok, ready, ack_hit;
  logic            icw1_wr, ocw2_wr, ocw3_wr;
  logic [NLVL-1:0] rise, req_eff, blk;

  assign ready    = (st == ST_RDY);
  assign rise     = irq_in & ~irq_q;
  assign req_eff  = irr & ~imr;
  assign blk      = smm ? '0 : isr;
  assign int_out  = win_ok & ready;
  assign ack_hit  = inta & int_out;
  assign icw1_wr  = cmd_wr & ~cmd_a0 & cmd_data[4];
  assign ocw2_wr  = cmd_wr & ~cmd_a0 & ~cmd_data[4] & ~cmd_data[3] & ready;
  assign ocw3_wr  = cmd_wr & ~cmd_a0 & ~cmd_data[4] &  cmd_data[3] & ready;
  assign stat_out = rd_isr ? isr : irr;
  assign mask_out = imr;

  always_comb begin
    logic stop;
    win_ok = 1'b0;
    win    = LW'(NLVL - 1);
    stop   = 1'b0;
    for (int i = 1; i <= NLVL; i++) begin
      logic [LW-1:0] lv;
      lv = LW'(int'(lowp) + i);
      if (!stop) begin
        if (blk[lv]) begin
          stop = 1'b1;
        end else if (req_eff[lv]) begin
          win_ok = 1'b1;
          win    = lv;
          stop   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    eoi_ok  = 1'b0;
    eoi_lvl = '0;
    for (int i = 1; i <= NLVL; i++) begin
      logic [LW-1:0] lv;
      lv = LW'(int'(lowp) + i);
      if (!eoi_ok && isr[lv] && !(smm && imr[lv])) begin
        eoi_ok  = 1'b1;
        eoi_lvl = lv;
      end
    end
  end

  always_comb begin
    st_n     = st;
    irr_n    = irr;
    isr_n    = isr;
    imr_n    = imr;
    lowp_n   = lowp;
    base_n   = base;
    smm_n    = smm;
    rd_isr_n = rd_isr;
    aeoi_n   = aeoi;
    rot_n    = rot_aeoi;
    need3_n  = need3;
    need4_n  = need4;

    if (ack_hit) begin
      irr_n[win] = 1'b0;
      if (aeoi) begin
        if (rot_aeoi) lowp_n = win;
      end else begin
        isr_n[win] = 1'b1;
      end
    end
    irr_n = irr_n | rise;

    if (icw1_wr) begin
      st_n     = ST_W2;
      need4_n  = cmd_data[0];
      need3_n  = ~cmd_data[1];
      imr_n    = '0;
      rd_isr_n = 1'b0;
      smm_n    = 1'b0;
      aeoi_n   = 1'b0;
      rot_n    = 1'b0;
      lowp_n   = LW'(NLVL - 1);
    end else if (cmd_wr && cmd_a0) begin
      case (st)
        ST_RDY: imr_n = cmd_data[NLVL-1:0];
        ST_W2: begin
          base_n = cmd_data[7:LW];
          st_n   = need3 ? ST_W3 : (need4 ? ST_W4 : ST_RDY);
        end
        ST_W3: st_n = need4 ? ST_W4 : ST_RDY;
        default: begin
          aeoi_n = cmd_data[1];
          st_n   = ST_RDY;
        end
      endcase
    end else if (ocw2_wr) begin
      if (cmd_data[5]) begin
        if (cmd_data[6]) begin
          isr_n[cmd_data[LW-1:0]] = 1'b0;
          if (cmd_data[7]) lowp_n = cmd_data[LW-1:0];
        end else if (eoi_ok) begin
          isr_n[eoi_lvl] = 1'b0;
          if (cmd_data[7]) lowp_n = eoi_lvl;
        end
      end else if (cmd_data[6]) begin
        if (cmd_data[7]) lowp_n = cmd_data[LW-1:0];
      end else begin
        rot_n = cmd_data[7];
      end
    end else if (ocw3_wr) begin
      if (cmd_data[6]) smm_n = cmd_data[5];
      if (cmd_data[1]) rd_isr_n = cmd_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RDY;
      irq_q    <= '0;
      irr      <= '0;
      isr      <= '0;
      imr      <= '0;
      lowp     <= LW'(NLVL - 1);
      base     <= '0;
      smm      <= 1'b0;
      rd_isr   <= 1'b0;
      aeoi     <= 1'b0;
      rot_aeoi <= 1'b0;
      need3    <= 1'b0;
      need4    <= 1'b0;
      vec_out  <= '0;
      vec_vld  <= 1'b0;
    end else begin
      st       <= st_n;
      irq_q    <= irq_in;
      irr      <= irr_n;
      isr      <= isr_n;
      imr      <= imr_n;
      lowp     <= lowp_n;
      base     <= base_n;
      smm      <= smm_n;
      rd_isr   <= rd_isr_n;
      aeoi     <= aeoi_n;
      rot_aeoi <= rot_n;
      need3    <= need3_n;
      need4    <= need4_n;
      vec_vld  <= inta;
      if (inta) vec_out <= {base, ack_hit ? win : LW'(NLVL - 1)};
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NLVL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inta,
  input logic            int_out,
  input logic            cmd_wr,
  input logic            icw1_wr,
  input logic            ready,
  input logic            vec_vld,
  input logic [7:0]      vec_out,
  input logic [NLVL-1:0] isr,
  input logic [NLVL-1:0] irr,
  input logic [NLVL-1:0] imr,
  input logic [$clog2(NLVL)-1:0] lowp,
  input logic            smm,
  input logic            aeoi
);
  localparam int LW = $clog2(NLVL);

  AST_ICW1_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_wr |=> (imr == '0 && lowp == LW'(NLVL - 1) && !smm)); // R2

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&imr) |-> !int_out); // R4

  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi && !cmd_wr) |=> (vec_vld && isr[vec_out[LW-1:0]])); // R5

  AST_SMM_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (smm && ready && |(irr & ~imr)) |-> int_out); // R10

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && aeoi && !cmd_wr) |=> $stable(isr)); // R12

  AST_SPURIOUS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |=> (vec_vld && vec_out[LW-1:0] == LW'(NLVL - 1))); // R14
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk_i (.*);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cmd_wr = 1'b0;
  logic       cmd_a0 = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       inta = 1'b0;
  logic       int_out, vec_vld;
  logic [7:0] vec_out, stat_out, mask_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_wr(cmd_wr), .cmd_a0(cmd_a0),
    .cmd_data(cmd_data), .inta(inta), .int_out(int_out), .vec_out(vec_out),
    .vec_vld(vec_vld), .stat_out(stat_out), .mask_out(mask_out)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_a0 = a0; cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  task automatic ack(input logic [7:0] exp);
    exp_q.push_back(exp);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic ack_edge(input logic [7:0] m, input logic [7:0] exp);
    exp_q.push_back(exp);
    @(negedge clk);
    inta = 1'b1;
    irq_in = irq_in | m;
    @(negedge clk);
    inta = 1'b0;
    irq_in = irq_in & ~m;
  endtask

  always @(negedge clk) begin
    if (vec_vld) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R5 unexpected vector act=%02h exp=none", vec_out);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec_out !== e) begin
          nfail++;
          $display("FAIL R5 vector act=%02h exp=%02h", vec_out, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset int", {7'd0, int_out}, 8'h00);
    chk("R1 reset stat", stat_out, 8'h00);

    wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h01);

    pulse(8'h24);
    chk("R3 int on request", {7'd0, int_out}, 8'h01);
    ack(8'h42);
    wr(0, 8'h0B);
    chk("R5 isr after ack", stat_out, 8'h04);
    chk("R3 blocked by service", {7'd0, int_out}, 8'h00);
    wr(0, 8'h20);
    chk("R6 eoi reopens", {7'd0, int_out}, 8'h01);
    ack(8'h45);
    chk("R5 isr level5", stat_out, 8'h20);
    wr(0, 8'h20);
    chk("R6 isr clear", stat_out, 8'h00);

    wr(1, 8'h08);
    pulse(8'h08);
    chk("R4 masked quiet", {7'd0, int_out}, 8'h00);
    wr(0, 8'h0A);
    chk("R1 irr read", stat_out, 8'h08);
    wr(1, 8'h00);
    chk("R4 unmask raises", {7'd0, int_out}, 8'h01);
    ack(8'h43);
    wr(0, 8'h20);

    pulse(8'h02);
    ack(8'h41);
    wr(0, 8'hA0);
    pulse(8'h09);
    ack(8'h43);          // R8 level 3 beats level 0 after rotation
    wr(0, 8'h20);
    ack(8'h40);
    wr(0, 8'h20);

    wr(0, 8'hC5);
    pulse(8'h50);
    ack(8'h46);          // R9 level 6 first after lowest=5
    wr(0, 8'h20);
    ack(8'h44);
    wr(0, 8'h20);

    pulse(8'h04);
    ack(8'h42);
    pulse(8'h80);
    chk("R3 higher level interrupts", {7'd0, int_out}, 8'h01);
    ack(8'h47);
    wr(0, 8'h0B);
    chk("R7 isr before", stat_out, 8'h84);
    wr(0, 8'h62);
    chk("R7 specific eoi", stat_out, 8'h80);
    wr(0, 8'h20);
    chk("R6 final eoi", stat_out, 8'h00);

    wr(0, 8'hC7);
    wr(0, 8'h68);
    pulse(8'h04);
    ack(8'h42);
    pulse(8'h20);
    chk("R10 smm lets lower in", {7'd0, int_out}, 8'h01);
    ack(8'h45);
    wr(1, 8'h04);
    wr(0, 8'h20);
    wr(0, 8'h0B);
    chk("R11 masked isr kept", stat_out, 8'h04);
    wr(0, 8'h2B);
    pulse(8'h40);
    chk("R10 ungated write ignored", {7'd0, int_out}, 8'h01);
    ack(8'h46);
    wr(0, 8'h48);
    pulse(8'h10);
    chk("R10 smm off blocks", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00);
    wr(0, 8'h20);
    ack(8'h44);
    wr(0, 8'h20);
    wr(0, 8'h20);
    chk("R6 all retired", stat_out, 8'h00);

    wr(1, 8'hF0);
    wr(0, 8'hC3);
    wr(0, 8'h13);
    chk("R2 mask cleared", mask_out, 8'h00);
    wr(1, 8'h40); wr(1, 8'h03);
    pulse(8'h81);
    ack(8'h40);          // R2 lowest reset to 7 so level 0 wins
    wr(0, 8'h0B);
    chk("R12 aeoi no isr", stat_out, 8'h00);
    chk("R12 next pending", {7'd0, int_out}, 8'h01);
    ack(8'h47);
    wr(0, 8'h80);
    pulse(8'h08);
    ack(8'h43);
    pulse(8'h24);
    ack(8'h45);          // R12 rotation made level 3 lowest
    ack(8'h42);

    pulse(8'h02);
    ack_edge(8'h02, 8'h41);
    chk("R13 still pending", {7'd0, int_out}, 8'h01);
    ack(8'h41);
    chk("R13 drained", {7'd0, int_out}, 8'h00);

    ack(8'h47);          // R14 spurious vector
    wr(0, 8'h0A);
    chk("R14 irr untouched", stat_out, 8'h00);
    chk("R14 int low", {7'd0, int_out}, 8'h00);

    repeat (3) @(negedge clk);
    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R5 missing vectors act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule